// File: doc/BRIEF.md
# Timer Output-Compare Channel

One output-compare channel of a general-purpose timer. An external counter supplies its current count, its direction and a strobe that marks the cycles where the count is valid for matching, plus an update-event pulse. The channel holds a compare value that a bus can write, either straight into the active register or through a shadow copy that moves across on update events. From the count and the compare value it builds an active-high reference signal using one of eight behaviours: hold, set, clear or toggle on match, force low or high, and two direction-aware PWM shapes.

An enable bit lets a high level on a trigger input force the reference low. The reference drives a main output and a complementary output, each with its own polarity bit. A configuration write port loads the behaviour, shadow enable, trigger-clear enable, channel direction select and the two polarity bits. The behaviour field is frozen when the protection level is at its highest and the channel is in compare direction.

The reference is registered. Every input seen in one clock shows on `ref_o` and the two pin outputs after that clock's rising edge.

Top module: `oc_channel`

## Requirements
- R1: After reset the behaviour code is 000, shadow and trigger clear are off, channel select is 00, both polarity bits are 0, the active compare value is 0 and `ref_o` is low.
- R2: Code 001 sets the reference high and code 010 clears it low in the cycle after a cycle where `cnt_en` is high and `cnt_val` equals the active compare value. A match with `cnt_en` low has no effect.
- R3: Code 011 inverts the reference after each qualified match (as defined in R2) and holds it otherwise.
- R4: Code 100 forces the reference low and code 101 forces it high, whatever the count.
- R5: Code 000 keeps the reference at its current value.
- R6: Code 110 (PWM A): when `cnt_up`=1 the reference is high while `cnt_val` is less than the compare value. When `cnt_up`=0 it is high while `cnt_val` is not greater than the compare value. The comparison is evaluated every clock.
- R7: Code 111 (PWM B) gives the inverse of PWM A in both directions.
- R8: With the trigger-clear bit set, a high `trig_in` drives the reference low in the next cycle, and normal evaluation resumes in the cycle after `trig_in` falls. With the bit clear, `trig_in` has no effect.
- R9: With shadow off, a compare write reaches `cmp_active` on the next cycle. With shadow on, the write goes to the shadow copy, and `cmp_active` takes the shadow value only on an `upd_evt` cycle. A write and an update in the same cycle move the old shadow value.
- R10: In compare direction (select 00), `out_main` = `ref_o` XOR main polarity and `out_comp` = NOT `ref_o` XOR complementary polarity. A polarity bit of 1 means active low.
- R11: A select value of 01, 10 or 11 marks the channel as an input. Both outputs then sit at their inactive level, equal to their own polarity bit.
- R12: A configuration write leaves the behaviour code unchanged when `prot_lvl` is 11 and the stored select is 00. All other fields in that write still load, and the behaviour code loads normally at any other protection level or select value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | CW | Counter value |
| cnt_up | input | 1 | Count direction, 1 = up |
| cnt_en | input | 1 | Count valid for matching this cycle |
| upd_evt | input | 1 | Update-event pulse |
| trig_in | input | 1 | External trigger for reference clear |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | CW | Compare value write data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Behaviour code |
| cfg_shadow | input | 1 | Shadow enable |
| cfg_clr_en | input | 1 | Trigger-clear enable |
| cfg_sel | input | 2 | Channel direction select |
| cfg_pol_main | input | 1 | Main output polarity |
| cfg_pol_comp | input | 1 | Complementary output polarity |
| prot_lvl | input | 2 | Protection level |
| ref_o | output | 1 | Active-high reference |
| out_main | output | 1 | Main output |
| out_comp | output | 1 | Complementary output |
| cmp_active | output | CW | Active compare value |

## Verification
The bench targets the boundary between PWM directions at count equal to compare. A design that used the up-count test while counting down would drop the reference one count early. It checks that a match with the strobe low leaves set, clear and toggle idle, because a design that ignored the strobe would toggle twice on a held count. It also covers a compare write that coincides with an update event under shadowing, where a wrong design would load the new value at once. Finally it checks the lock with a write that changes several fields together, where a design that blocked the whole write would also freeze the polarities.

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_up,
  input  logic          cnt_en,
  input  logic          upd_evt,
  input  logic          trig_in,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_wdata,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_mode,
  input  logic          cfg_shadow,
  input  logic          cfg_clr_en,
  input  logic [1:0]    cfg_sel,
  input  logic          cfg_pol_main,
  input  logic          cfg_pol_comp,
  input  logic [1:0]    prot_lvl,
  output logic          ref_o,
  output logic          out_main,
  output logic          out_comp,
  output logic [CW-1:0] cmp_active
);

  logic [2:0]    mode_q;
  logic          shadow_q, clr_q, pol_main_q, pol_comp_q, ref_q;
  logic [1:0]    sel_q;
  logic [CW-1:0] cmp_act, cmp_shd;

  wire hit     = cnt_en && (cnt_val == cmp_act);
  wire below   = cnt_val < cmp_act;
  wire above   = cnt_val > cmp_act;
  wire pwm_a   = cnt_up ? below : !above;
  wire locked  = (prot_lvl == 2'b11) && (sel_q == 2'b00);
  wire is_out  = (sel_q == 2'b00);

  logic ref_d;
  always_comb begin
    ref_d = ref_q;
    if (clr_q && trig_in) ref_d = 1'b0;
    else begin
      case (mode_q)
        3'b001:  if (hit) ref_d = 1'b1;
        3'b010:  if (hit) ref_d = 1'b0;
        3'b011:  if (hit) ref_d = !ref_q;
        3'b100:  ref_d = 1'b0;
        3'b101:  ref_d = 1'b1;
        3'b110:  ref_d = pwm_a;
        3'b111:  ref_d = !pwm_a;
        default: ref_d = ref_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= 3'b000;
      shadow_q   <= 1'b0;
      clr_q      <= 1'b0;
      sel_q      <= 2'b00;
      pol_main_q <= 1'b0;
      pol_comp_q <= 1'b0;
    end else if (cfg_we) begin
      if (!locked) mode_q <= cfg_mode;
      shadow_q   <= cfg_shadow;
      clr_q      <= cfg_clr_en;
      sel_q      <= cfg_sel;
      pol_main_q <= cfg_pol_main;
      pol_comp_q <= cfg_pol_comp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_act <= '0;
      cmp_shd <= '0;
      ref_q   <= 1'b0;
    end else begin
      ref_q <= ref_d;
      if (cmp_we) cmp_shd <= cmp_wdata;
      if (cmp_we && !shadow_q) cmp_act <= cmp_wdata;
      else if (shadow_q && upd_evt) cmp_act <= cmp_shd;
    end
  end

  assign ref_o      = ref_q;
  assign cmp_active = cmp_act;
  assign out_main   = is_out ? (ref_q ^ pol_main_q) : pol_main_q;
  assign out_comp   = is_out ? (!ref_q ^ pol_comp_q) : pol_comp_q;

endmodule

module oc_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig_in,
  input logic          cmp_we,
  input logic [CW-1:0] cmp_wdata,
  input logic          upd_evt,
  input logic          cfg_we,
  input logic [1:0]    prot_lvl,
  input logic [2:0]    mode_q,
  input logic          shadow_q,
  input logic          clr_q,
  input logic [1:0]    sel_q,
  input logic          ref_o,
  input logic [CW-1:0] cmp_active
);

  assert_force_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b101 && !(clr_q && trig_in)) |=> ref_o);

  assert_timing_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b000 && !(clr_q && trig_in)) |=> $stable(ref_o));

  assert_trig_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && trig_in) |=> !ref_o);

  assert_direct_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!shadow_q && cmp_we) |=> (cmp_active == $past(cmp_wdata)));

  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_q && !upd_evt) |=> $stable(cmp_active));

  assert_mode_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && prot_lvl == 2'b11 && sel_q == 2'b00) |=> $stable(mode_q));

endmodule

bind oc_channel oc_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cmp_we(cmp_we),
  .cmp_wdata(cmp_wdata), .upd_evt(upd_evt), .cfg_we(cfg_we),
  .prot_lvl(prot_lvl), .mode_q(mode_q), .shadow_q(shadow_q),
  .clr_q(clr_q), .sel_q(sel_q), .ref_o(ref_o), .cmp_active(cmp_active)
);

// File: tb/sim_oc_channel.sv
module sim_oc_channel;
  localparam int CW = 16;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] cnt_val = '0, cmp_wdata = '0;
  logic cnt_up = 1'b1, cnt_en = 1'b0, upd_evt = 1'b0, trig_in = 1'b0, cmp_we = 1'b0;
  logic cfg_we = 1'b0, cfg_shadow = 1'b0, cfg_clr_en = 1'b0, cfg_pol_main = 1'b0, cfg_pol_comp = 1'b0;
  logic [2:0] cfg_mode = 3'b000;
  logic [1:0] cfg_sel = 2'b00, prot_lvl = 2'b00;
  logic ref_o, out_main, out_comp;
  logic [CW-1:0] cmp_active;

  oc_channel #(.CW(CW)) u0 (.*);

  always #(PERIOD/2) clk = !clk;

  int checks = 0, errors = 0;
  string req = "R1";
  bit done = 1'b0;

  // behavioural model
  int m_mode, m_sel, m_act, m_shd;
  bit m_sh, m_clr, m_pm, m_pc, m_ref;

  always @(posedge clk) begin
    int n_act, n_shd, c, k;
    bit n_ref;
    if (!rst_n) begin
      m_mode = 0; m_sel = 0; m_act = 0; m_shd = 0;
      m_sh = 0; m_clr = 0; m_pm = 0; m_pc = 0; m_ref = 0;
    end else begin
      c = int'(cnt_val); k = m_act;
      n_ref = m_ref;
      if (m_clr && trig_in) n_ref = 0;
      else if (m_mode == 1 && cnt_en && c == k) n_ref = 1;
      else if (m_mode == 2 && cnt_en && c == k) n_ref = 0;
      else if (m_mode == 3 && cnt_en && c == k) n_ref = !m_ref;
      else if (m_mode == 4) n_ref = 0;
      else if (m_mode == 5) n_ref = 1;
      else if (m_mode >= 6) begin
        n_ref = cnt_up ? (c < k) : (c <= k);
        if (m_mode == 7) n_ref = !n_ref;
      end
      n_shd = cmp_we ? int'(cmp_wdata) : m_shd;
      n_act = m_act;
      if (!m_sh && cmp_we) n_act = int'(cmp_wdata);
      else if (m_sh && upd_evt) n_act = m_shd;
      if (cfg_we) begin
        if (!(prot_lvl == 2'b11 && m_sel == 0)) m_mode = int'(cfg_mode);
        m_sh = cfg_shadow; m_clr = cfg_clr_en; m_sel = int'(cfg_sel);
        m_pm = cfg_pol_main; m_pc = cfg_pol_comp;
      end
      m_ref = n_ref; m_act = n_act; m_shd = n_shd;
    end
  end

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic compare();
    bit em, ec;
    em = (m_sel == 0) ? (m_ref ^ m_pm) : m_pm;
    ec = (m_sel == 0) ? (!m_ref ^ m_pc) : m_pc;
    chk(req, "ref_o", int'(ref_o), int'(m_ref));
    chk((m_sel == 0) ? "R10" : "R11", "out_main", int'(out_main), int'(em));
    chk((m_sel == 0) ? "R10" : "R11", "out_comp", int'(out_comp), int'(ec));
    chk("R9", "cmp_active", int'(cmp_active), m_act);
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    compare();
  endtask

  task automatic cfg(int md, bit sh, bit cl, int sl, bit pm, bit pc);
    cfg_we = 1; cfg_mode = 3'(md); cfg_shadow = sh; cfg_clr_en = cl;
    cfg_sel = 2'(sl); cfg_pol_main = pm; cfg_pol_comp = pc;
    tick();
    cfg_we = 0;
  endtask

  task automatic wr_cmp(int v);
    cmp_we = 1; cmp_wdata = CW'(v); tick(); cmp_we = 0;
  endtask

  task automatic sweep(bit up, int lo, int hi);
    cnt_up = up; cnt_en = 1;
    for (int i = 0; i <= hi - lo; i++) begin
      cnt_val = CW'(up ? lo + i : hi - i);
      tick();
    end
    cnt_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    req = "R1";
    chk("R1", "reset ref", int'(ref_o), 0);
    chk("R1", "reset cmp", int'(cmp_active), 0);
    chk("R1", "reset out_main", int'(out_main), 0);
    chk("R1", "reset out_comp", int'(out_comp), 1);

    req = "R2";
    wr_cmp(5);
    cfg(1, 0, 0, 0, 0, 0);
    cnt_val = 5; cnt_en = 0; tick(); tick();
    chk("R2", "no strobe no set", int'(ref_o), 0);
    sweep(1, 0, 9);
    chk("R2", "set on match", int'(ref_o), 1);
    cfg(2, 0, 0, 0, 0, 0);
    sweep(1, 0, 9);
    chk("R2", "clear on match", int'(ref_o), 0);

    req = "R3";
    cfg(3, 0, 0, 0, 0, 0);
    sweep(1, 0, 9); sweep(0, 0, 9); sweep(1, 3, 6);
    cnt_val = 5; cnt_en = 1; tick(); tick(); tick(); cnt_en = 0;

    req = "R4";
    cfg(5, 0, 0, 0, 0, 0); sweep(1, 0, 7);
    chk("R4", "force high", int'(ref_o), 1);
    cfg(4, 0, 0, 0, 0, 0); sweep(1, 0, 7);
    chk("R4", "force low", int'(ref_o), 0);

    req = "R5";
    cfg(5, 0, 0, 0, 0, 0);
    cfg(0, 0, 0, 0, 0, 0); sweep(1, 0, 9); sweep(0, 0, 9);
    chk("R5", "timing hold", int'(ref_o), 1);

    req = "R6";
    cfg(6, 0, 0, 0, 0, 0);
    sweep(1, 0, 9); sweep(0, 0, 9);
    cnt_up = 0; cnt_val = 5; tick();
    chk("R6", "pwm A down at equal", int'(ref_o), 1);
    cnt_up = 1; cnt_val = 5; tick();
    chk("R6", "pwm A up at equal", int'(ref_o), 0);

    req = "R7";
    cfg(7, 0, 0, 0, 0, 0);
    sweep(1, 0, 9); sweep(0, 0, 9);

    req = "R8";
    cfg(5, 0, 1, 0, 0, 0);
    trig_in = 1; tick(); tick();
    chk("R8", "trigger clears", int'(ref_o), 0);
    trig_in = 0; tick();
    chk("R8", "resume after trigger", int'(ref_o), 1);
    cfg(5, 0, 0, 0, 0, 0);
    trig_in = 1; tick(); tick();
    chk("R8", "trigger ignored when disabled", int'(ref_o), 1);
    trig_in = 0;
    cfg(7, 0, 1, 0, 0, 0);
    cnt_up = 1; cnt_en = 1;
    for (int i = 0; i < 10; i++) begin
      cnt_val = CW'(i); trig_in = (i % 3 == 1); tick();
    end
    trig_in = 0; cnt_en = 0;

    req = "R9";
    cfg(6, 1, 0, 0, 0, 0);
    wr_cmp(20);
    chk("R9", "shadow hides write", int'(cmp_active), 5);
    upd_evt = 1; tick(); upd_evt = 0;
    chk("R9", "update loads shadow", int'(cmp_active), 20);
    cmp_we = 1; cmp_wdata = 30; upd_evt = 1; tick(); cmp_we = 0; upd_evt = 0;
    chk("R9", "write+update moves old", int'(cmp_active), 20);
    upd_evt = 1; tick(); upd_evt = 0;
    chk("R9", "next update", int'(cmp_active), 30);
    sweep(1, 25, 35);
    cfg(6, 0, 0, 0, 0, 0);
    wr_cmp(4);
    chk("R9", "direct write", int'(cmp_active), 4);

    req = "R10";
    cfg(6, 0, 0, 0, 1, 0); sweep(1, 0, 7);
    cfg(6, 0, 0, 0, 0, 1); sweep(0, 0, 7);
    cfg(6, 0, 0, 0, 1, 1); sweep(1, 0, 7);

    req = "R11";
    for (int s = 1; s < 4; s++) begin
      cfg(5, 0, 0, s, s[0], s[1]); sweep(1, 0, 4);
      chk("R11", "inactive main", int'(out_main), s & 1);
    end

    req = "R12";
    cfg(5, 0, 0, 0, 0, 0);
    prot_lvl = 2'b11;
    cfg(4, 0, 0, 0, 1, 0); tick();
    chk("R12", "mode locked ref", int'(ref_o), 1);
    chk("R12", "polarity still loads", int'(out_main), 0);
    prot_lvl = 2'b10;
    cfg(4, 0, 0, 0, 0, 0); tick();
    chk("R12", "mode loads below top level", int'(ref_o), 0);
    prot_lvl = 2'b11;
    cfg(4, 0, 0, 1, 0, 0);
    cfg(5, 0, 0, 0, 0, 0); tick();
    chk("R12", "mode loads when input", int'(ref_o), 1);
    prot_lvl = 2'b00;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule